// File: doc/BRIEF.md
# Shifted-Mask Seed Pre-Alignment Filter

This block screens candidate read placements before they reach an expensive alignment stage. Every cycle it can accept one pair: a short read of nucleotides and a reference segment of equal length, both packed two bits per base, plus a run-time edit budget E. Two clock cycles later it reports whether the pair could align within E edits. A rejected pair can be dropped by the caller. An accepted pair goes on to exact verification.

The decision takes two routes. The first compares the bases position by position and counts the mismatching bases. If that count fits the budget, the pair is accepted as substitution-only. Otherwise the block builds extra mismatch masks with the read displaced by one to E bases in each direction, which models deletions and insertions. Each mask has its short runs of matches (one or two bases) overwritten as mismatches. The masks are then ANDed, and the ones that remain are counted and compared against E. Read length and the largest budget are compile-time parameters. A tag travels with each pair so that results can be matched to their requests.

Top module: `shifted_mask_filter`

## Requirements
- R1: Base i of read and reference occupies bits [2i+1:2i]. A base mismatches when its two bits differ in either position, which yields one mask bit per base (1 = mismatch).
- R2: When the number of mismatching bases with no displacement is at most E, the pair is accepted, `out_subst` is 1 and `out_cnt` equals that number.
- R3: For displacement s, the deletion mask compares reference base i with read base i-s and the insertion mask compares reference base i with read base i+s. Positions with no partner base read as a match.
- R4: In every mask, a run of one or two matches with a mismatch on both sides becomes all mismatches. Runs of three or more matches are kept.
- R5: The first and last bit of every mask pass through amendment unchanged.
- R6: The amended masks are combined by bitwise AND. The masks for displacements larger than E are forced to all ones and have no effect.
- R7: When R2 does not accept, `out_subst` is 0, `out_cnt` is the number of ones in the merged vector, and `out_accept` is 1 exactly when that count is at most E.
- R8: A requested E above the compiled maximum is treated as that maximum.
- R9: A pair whose read differs from the reference by one inserted or deleted base, with long matching stretches on both sides, is accepted when E is at least 1.
- R10: A result appears with `out_valid` exactly two cycles after `in_valid`, carrying the input tag. Pairs may arrive on back-to-back cycles.
- R11: While reset is held, and until the first result, `out_valid` and `out_accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pair present on the inputs |
| in_tag | input | TAG_W | Request identifier |
| in_e | input | $clog2(MAX_E+1) | Edit budget for this pair |
| in_read | input | 2*READ_LEN | Packed read bases |
| in_ref | input | 2*READ_LEN | Packed reference bases |
| out_valid | output | 1 | Result present |
| out_tag | output | TAG_W | Identifier of the result |
| out_accept | output | 1 | Pair may align within the budget |
| out_subst | output | 1 | Decided by the substitution-only count |
| out_cnt | output | $clog2(READ_LEN+1) | Reported edit estimate |

## Verification
Identical pairs and pairs with a few scattered substitutions show whether the substitution-only route accepts and reports the exact count. Reads that are the reference with one base removed or one base added tell the deletion masks apart from the insertion masks. Comparing the same pair at budgets 0 and 1 shows that masks for unused displacements are switched off. Mismatch patterns with isolated matches, paired matches and three-long matches separate the amendment rule from a plain AND. Opposite-base sequences run at budgets 2, 4 and 7 check how the displacement count grows and that the budget saturates at the compiled maximum. A back-to-back stream of mixed pairs checks tag order and the two-cycle latency.

// File: rtl/dnaf_pkg.sv
package dnaf_pkg;
  // Direction in which the read is displaced against the reference
  typedef enum logic {
    SH_DEL = 1'b0,  // compare reference base i with read base i-s
    SH_INS = 1'b1   // compare reference base i with read base i+s
  } shift_dir_e;
endpackage

// File: rtl/base_compare.sv
module base_compare
  import dnaf_pkg::*;
#(
  parameter int         READ_LEN = 16,
  parameter int         SHIFT    = 0,
  parameter shift_dir_e DIR      = SH_DEL
) (
  input  logic [2*READ_LEN-1:0] read_i,
  input  logic [2*READ_LEN-1:0] ref_i,
  output logic [READ_LEN-1:0]   mask_o
);
  // One mask bit per base; bases without a partner count as matching
  for (genvar i = 0; i < READ_LEN; i++) begin : g_base
    if (DIR == SH_DEL && i >= SHIFT) begin : g_del
      assign mask_o[i] = |(ref_i[2*i +: 2] ^ read_i[2*(i-SHIFT) +: 2]);
    end else if (DIR == SH_INS && i + SHIFT < READ_LEN) begin : g_ins
      assign mask_o[i] = |(ref_i[2*i +: 2] ^ read_i[2*(i+SHIFT) +: 2]);
    end else begin : g_fill
      assign mask_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/streak_amend.sv
module streak_amend #(
  parameter int W = 16
) (
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] mask_o
);
  // Pad with matches so that edge windows see no bounding mismatch
  logic [W+3:0] pad;
  assign pad = {2'b00, mask_i, 2'b00};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0 || i == W - 1) begin : g_edge
      assign mask_o[i] = mask_i[i];
    end else begin : g_mid
      logic m2, m1, p1, p2;  // neighbours at i-2, i-1, i+1, i+2
      assign m2 = pad[i];
      assign m1 = pad[i+1];
      assign p1 = pad[i+3];
      assign p2 = pad[i+4];
      assign mask_o[i] = mask_i[i]
                       | (m1 & p1)            // lone match
                       | (m1 & ~p1 & p2)      // first of a pair
                       | (m2 & ~m1 & p1);     // second of a pair
    end
  end
endmodule

// File: rtl/pop_count.sv
module pop_count #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/shifted_mask_filter.sv
module shifted_mask_filter
  import dnaf_pkg::*;
#(
  parameter  int READ_LEN = 16,
  parameter  int MAX_E    = 4,
  parameter  int TAG_W    = 4,
  localparam int E_W      = $clog2(MAX_E + 1),
  localparam int CW       = $clog2(READ_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [E_W-1:0]        in_e,
  input  logic [2*READ_LEN-1:0] in_read,
  input  logic [2*READ_LEN-1:0] in_ref,
  output logic                  out_valid,
  output logic [TAG_W-1:0]      out_tag,
  output logic                  out_accept,
  output logic                  out_subst,
  output logic [CW-1:0]         out_cnt
);
  // ---------------- reset release synchroniser ----------------
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // ---------------- budget clamp (R8) ----------------
  logic [E_W-1:0] e_eff;
  assign e_eff = (in_e > E_W'(MAX_E)) ? E_W'(MAX_E) : in_e;

  // ---------------- unshifted mask ----------------
  logic [READ_LEN-1:0] raw0, amd0;
  logic [CW-1:0]       ham_cnt;

  base_compare #(.READ_LEN(READ_LEN), .SHIFT(0), .DIR(SH_DEL)) u_cmp0 (
    .read_i(in_read), .ref_i(in_ref), .mask_o(raw0));
  streak_amend #(.W(READ_LEN)) u_amd0 (.mask_i(raw0), .mask_o(amd0));
  pop_count #(.W(READ_LEN), .CW(CW)) u_ham (.bits_i(raw0), .cnt_o(ham_cnt));

  // ---------------- displaced masks ----------------
  logic [READ_LEN-1:0] raw_del [1:MAX_E];
  logic [READ_LEN-1:0] raw_ins [1:MAX_E];
  logic [READ_LEN-1:0] amd_del [1:MAX_E];
  logic [READ_LEN-1:0] amd_ins [1:MAX_E];
  logic [READ_LEN-1:0] use_del [1:MAX_E];
  logic [READ_LEN-1:0] use_ins [1:MAX_E];

  for (genvar s = 1; s <= MAX_E; s++) begin : g_shift
    logic in_use;
    assign in_use = (E_W'(s) <= e_eff);

    base_compare #(.READ_LEN(READ_LEN), .SHIFT(s), .DIR(SH_DEL)) u_cmp_del (
      .read_i(in_read), .ref_i(in_ref), .mask_o(raw_del[s]));
    base_compare #(.READ_LEN(READ_LEN), .SHIFT(s), .DIR(SH_INS)) u_cmp_ins (
      .read_i(in_read), .ref_i(in_ref), .mask_o(raw_ins[s]));
    streak_amend #(.W(READ_LEN)) u_amd_del (.mask_i(raw_del[s]), .mask_o(amd_del[s]));
    streak_amend #(.W(READ_LEN)) u_amd_ins (.mask_i(raw_ins[s]), .mask_o(amd_ins[s]));

    assign use_del[s] = in_use ? amd_del[s] : '1;
    assign use_ins[s] = in_use ? amd_ins[s] : '1;

    // Amendment may only turn matches into mismatches
    p_amend_sets_r4: assert property (@(posedge clk) disable iff (!srst_n)
      ((amd_del[s] & raw_del[s]) == raw_del[s]) && ((amd_ins[s] & raw_ins[s]) == raw_ins[s]));
  end

  logic [READ_LEN-1:0] merged;
  always_comb begin
    merged = amd0;
    for (int s = 1; s <= MAX_E; s++) begin
      merged = merged & use_del[s] & use_ins[s];
    end
  end

  // ---------------- stage 1 ----------------
  logic                s1_valid_d, s1_valid_q;
  logic [TAG_W-1:0]    s1_tag_d,   s1_tag_q;
  logic [E_W-1:0]      s1_e_d,     s1_e_q;
  logic [READ_LEN-1:0] s1_mrg_d,   s1_mrg_q;
  logic [CW-1:0]       s1_ham_d,   s1_ham_q;

  always_comb begin
    s1_valid_d = in_valid;
    s1_tag_d   = s1_tag_q;
    s1_e_d     = s1_e_q;
    s1_mrg_d   = s1_mrg_q;
    s1_ham_d   = s1_ham_q;
    if (in_valid) begin
      s1_tag_d = in_tag;
      s1_e_d   = e_eff;
      s1_mrg_d = merged;
      s1_ham_d = ham_cnt;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_valid_q <= 1'b0;
      s1_tag_q   <= '0;
      s1_e_q     <= '0;
      s1_mrg_q   <= '0;
      s1_ham_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_tag_q   <= s1_tag_d;
      s1_e_q     <= s1_e_d;
      s1_mrg_q   <= s1_mrg_d;
      s1_ham_q   <= s1_ham_d;
    end
  end

  // ---------------- stage 2: count and decide ----------------
  logic [CW-1:0] mrg_cnt;
  pop_count #(.W(READ_LEN), .CW(CW)) u_mrg (.bits_i(s1_mrg_q), .cnt_o(mrg_cnt));

  logic            fast_ok, slow_ok;
  assign fast_ok = (s1_ham_q <= CW'(s1_e_q));
  assign slow_ok = (mrg_cnt  <= CW'(s1_e_q));

  logic             o_valid_d, o_acc_d, o_sub_d;
  logic [TAG_W-1:0] o_tag_d;
  logic [CW-1:0]    o_cnt_d;

  always_comb begin
    o_valid_d = s1_valid_q;
    o_tag_d   = out_tag;
    o_acc_d   = out_accept;
    o_sub_d   = out_subst;
    o_cnt_d   = out_cnt;
    if (s1_valid_q) begin
      o_tag_d = s1_tag_q;
      o_sub_d = fast_ok;
      o_acc_d = fast_ok | slow_ok;
      o_cnt_d = fast_ok ? s1_ham_q : mrg_cnt;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_valid  <= 1'b0;
      out_tag    <= '0;
      out_accept <= 1'b0;
      out_subst  <= 1'b0;
      out_cnt    <= '0;
    end else begin
      out_valid  <= o_valid_d;
      out_tag    <= o_tag_d;
      out_accept <= o_acc_d;
      out_subst  <= o_sub_d;
      out_cnt    <= o_cnt_d;
    end
  end

  // ---------------- checks ----------------
  p_subst_accept_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && out_subst) |-> (out_accept && (out_cnt <= CW'($past(s1_e_q)))));

  p_indel_decide_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_subst) |-> (out_accept == (out_cnt <= CW'($past(s1_e_q)))));

  p_latency_r10: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid == $past(in_valid, 2));

  p_budget_clamp_r8: assert property (@(posedge clk) disable iff (!srst_n)
    s1_valid_q |-> (s1_e_q <= E_W'(MAX_E)));
endmodule

// File: tb/shifted_mask_filter_tb.sv
module shifted_mask_filter_tb;
  localparam int L   = 16;
  localparam int ME  = 4;
  localparam int TW  = 4;
  localparam int EW  = $clog2(ME + 1);
  localparam int CW  = $clog2(L + 1);
  localparam int NV  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [EW-1:0] in_e = '0;
  logic [2*L-1:0] in_read = '0;
  logic [2*L-1:0] in_ref = '0;
  logic          out_valid, out_accept, out_subst;
  logic [TW-1:0] out_tag;
  logic [CW-1:0] out_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  shifted_mask_filter #(.READ_LEN(L), .MAX_E(ME), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_e(in_e),
    .in_read(in_read), .in_ref(in_ref), .out_valid(out_valid), .out_tag(out_tag),
    .out_accept(out_accept), .out_subst(out_subst), .out_cnt(out_cnt));

  // Stimulus table: read, reference, budget
  localparam logic [2*L-1:0] T_RD [NV] = '{
    32'h1B1B_1B1B, 32'h1B1B_1B1B, 32'h1B1B_1B1B, 32'hE4E4_E4E4, 32'hE4E4_E4E4,
    32'h0123_4567, 32'hA5A5_0F0F, 32'hFFFF_0000, 32'hC3D2_E1F0, 32'h5555_5555};
  localparam logic [2*L-1:0] T_RF [NV] = '{
    32'h1B1B_1B1B, 32'h1B1B_1B18, 32'h1B1B_1B18, 32'h9393_9393, 32'h3939_3939,
    32'h89AB_CDEF, 32'hA5A5_3C0F, 32'h0000_FFFF, 32'hC3D2_E1F3, 32'h5554_5555};
  localparam int T_E [NV] = '{0, 1, 0, 1, 2, 4, 3, 7, 2, 0};

  // ---------------- reference model ----------------
  function automatic logic [L-1:0] mdl_mask(logic [2*L-1:0] rd, logic [2*L-1:0] rf,
                                            int sh, bit ins);
    logic [L-1:0] m = '0;
    for (int i = 0; i < L; i++) begin
      int j = ins ? i + sh : i - sh;
      if (j >= 0 && j < L) m[i] = (rd[2*j +: 2] != rf[2*i +: 2]);
    end
    return m;
  endfunction

  function automatic bit at(logic [L-1:0] m, int k);
    return (k < 0 || k >= L) ? 1'b0 : m[k];
  endfunction

  function automatic logic [L-1:0] mdl_amend(logic [L-1:0] m);
    logic [L-1:0] o = m;
    for (int i = 1; i < L - 1; i++) begin
      if (!m[i]) begin
        if (at(m, i-1) && at(m, i+1)) o[i] = 1'b1;
        if (at(m, i-1) && !at(m, i+1) && at(m, i+2)) o[i] = 1'b1;
        if (at(m, i-2) && !at(m, i-1) && at(m, i+1)) o[i] = 1'b1;
      end
    end
    return o;
  endfunction

  task automatic mdl(input logic [2*L-1:0] rd, input logic [2*L-1:0] rf, input int e,
                     output int acc, output int sub, output int cnt);
    int ec = (e > ME) ? ME : e;
    logic [L-1:0] raw0 = mdl_mask(rd, rf, 0, 1'b0);
    logic [L-1:0] mrg  = mdl_amend(raw0);
    int ham = $countones(raw0);
    int mc;
    for (int s = 1; s <= ec; s++) begin
      mrg = mrg & mdl_amend(mdl_mask(rd, rf, s, 1'b0)) & mdl_amend(mdl_mask(rd, rf, s, 1'b1));
    end
    mc  = $countones(mrg);
    sub = (ham <= ec) ? 1 : 0;
    cnt = sub ? ham : mc;
    acc = (sub || mc <= ec) ? 1 : 0;
  endtask

  // ---------------- helpers ----------------
  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_one(input logic [2*L-1:0] rd, input logic [2*L-1:0] rf,
                         input int e, input int tag);
    @(negedge clk);
    in_valid = 1'b1; in_read = rd; in_ref = rf; in_e = EW'(e); in_tag = TW'(tag);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [2*L-1:0] pack(int b []);
    logic [2*L-1:0] v = '0;
    for (int i = 0; i < L; i++) v[2*i +: 2] = 2'(b[i]);
    return v;
  endfunction

  // ---------------- main sequence ----------------
  initial begin
    int acc, sub, cnt;
    int b [];
    int r [];
    b = new[L];
    r = new[L];

    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", int'(out_valid), 0);
    chk("R11 out_accept in reset", int'(out_accept), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 out_valid after reset", int'(out_valid), 0);
    chk("R11 out_accept after reset", int'(out_accept), 0);

    // Table walked as a back-to-back stream (R10)
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        mdl(T_RD[k-2], T_RF[k-2], T_E[k-2], acc, sub, cnt);
        chk("R10 stream valid", int'(out_valid), 1);
        chk("R10 stream tag", int'(out_tag), (k - 2) % 16);
        chk("R7 stream accept", int'(out_accept), acc);
        chk("R2 stream subst", int'(out_subst), sub);
        chk("R7 stream count", int'(out_cnt), cnt);
      end
      if (k < NV) begin
        in_valid = 1'b1; in_read = T_RD[k]; in_ref = T_RF[k];
        in_e = EW'(T_E[k]); in_tag = TW'(k);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R10 valid drops after stream", int'(out_valid), 0);

    // Exact match and single substitution (R1, R2)
    run_one(32'h1B1B_1B1B, 32'h1B1B_1B1B, 0, 3);
    chk("R2 exact accept", int'(out_accept), 1);
    chk("R2 exact subst", int'(out_subst), 1);
    chk("R2 exact count", int'(out_cnt), 0);
    chk("R10 tag", int'(out_tag), 3);
    run_one(32'h0000_0000, 32'h0000_0002, 1, 5);
    chk("R1 one-bit base difference count", int'(out_cnt), 1);
    chk("R1 one-bit base difference subst", int'(out_subst), 1);

    // One base deleted from read at position 6 (R3, R6, R9)
    for (int i = 0; i < L; i++) b[i] = i % 4;
    for (int i = 0; i < L; i++) r[i] = (i < 6) ? b[i] : ((i < L-1) ? b[i+1] : 0);
    run_one(pack(r), pack(b), 0, 6);
    chk("R6 deletion, budget 0 reject", int'(out_accept), 0);
    chk("R6 deletion, budget 0 count", int'(out_cnt), 10);
    run_one(pack(r), pack(b), 1, 7);
    chk("R9 deletion accepted", int'(out_accept), 1);
    chk("R3 deletion via indel path", int'(out_subst), 0);
    chk("R3 deletion count", int'(out_cnt), 1);

    // One base inserted into read at position 6 (R3, R9)
    for (int i = 0; i < L; i++) r[i] = (i < 6) ? b[i] : ((i == 6) ? 0 : b[i-1]);
    run_one(pack(r), pack(b), 1, 8);
    chk("R9 insertion accepted", int'(out_accept), 1);
    chk("R3 insertion via indel path", int'(out_subst), 0);
    chk("R3 insertion count", int'(out_cnt), 0);

    // Amendment patterns at budget 0 (R4, R5): read all A
    run_one(32'h0, 32'h3333_3333, 0, 9);           // mismatch at even bases
    chk("R4 isolated matches amended, R5 last bit kept", int'(out_cnt), 15);
    chk("R4 isolated reject", int'(out_accept), 0);
    for (int i = 0; i < L; i++) r[i] = (i % 3 == 0) ? 3 : 0;
    run_one(32'h0, pack(r), 0, 10);
    chk("R4 paired matches amended", int'(out_cnt), 16);
    for (int i = 0; i < L; i++) r[i] = (i % 4 == 0) ? 3 : 0;
    run_one(32'h0, pack(r), 0, 11);
    chk("R4 triple matches kept", int'(out_cnt), 4);

    // All A against all T: displacement reach and clamp (R6, R8)
    run_one(32'h0, 32'hFFFF_FFFF, 2, 12);
    chk("R6 budget 2 count", int'(out_cnt), 12);
    run_one(32'h0, 32'hFFFF_FFFF, 4, 13);
    chk("R6 budget 4 count", int'(out_cnt), 8);
    chk("R7 budget 4 reject", int'(out_accept), 0);
    run_one(32'h0, 32'hFFFF_FFFF, 7, 14);
    chk("R8 budget 7 clamps to 4", int'(out_cnt), 8);
    chk("R8 clamp tag", int'(out_tag), 14);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule